// File: doc/BRIEF.md
# SAR Converter Sequencer

This block is the digital front end of a successive-approximation analog-to-digital converter. Software talks to it through a small 32-bit register bus with four word registers: the last conversion result, a busy flag, a control word, and a power-up settling count. Writing the control word with its power bit newly set does three things. It powers the analog core, waits the programmed number of converter-clock periods, and then resolves one sample on the selected channel.

The conversion runs one bit per clock, starting from the most significant bit. On each step the block drives a trial code to the DAC and reads a single comparator bit back. When the last bit resolves, the result is stored and an interrupt status flag is raised. The interrupt line follows that flag, gated by an enable bit. Software acknowledges by writing zero to the control word. That write clears the flag and removes power. The same write during a sequence abandons it.

Top module: `sar_ctrl_top`

## Requirements
- R1: After reset the result, busy, control and interrupt state read as zero, the settling count reads 8, and `adc_pwr`, `adc_chan`, `irq` and `dac_code` are low.
- R2: A read strobe returns, on `bus_rdata` in the following cycle, the register value from before that edge. Reads decode address bits [4:2] as follows: 0 is the result, zero-extended; 1 is status, with busy in bit 0; 2 is control; 3 is the settling count in bits [5:0]. Any other index reads zero.
- R3: A write to control with bit 3 set, while bit 3 was clear, starts exactly one sequence and busy reads 1 from the next cycle. Rewriting bit 3 as 1 while it is already 1 does not restart the sequence.
- R4: With settling count D, the first trial code appears D cycles after the start write edge. With D = 0 it appears in the cycle right after that edge.
- R5: A conversion lasts RES_BITS cycles, tries bits from MSB to LSB, and keeps a trial bit when `cmp_in` is high. `dac_code` shows the kept bits plus the current trial bit, and is zero outside conversion.
- R6: On the edge that resolves the last bit, the result register takes the converted value, control bit 6 (interrupt status) sets, and busy clears.
- R7: `irq` is high exactly when interrupt status (control bit 6) and interrupt enable (control bit 5) are both set.
- R8: Writing 0 to control clears interrupt status and power. Writing bit 6 as 1 never sets the status.
- R9: Clearing bit 3 during settling or conversion returns to idle on that edge. The result is left unchanged and the status is not set.
- R10: `adc_chan` follows control bits [2:0] and `adc_pwr` follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | RES_BITS | Trial code to the DAC |
| adc_chan | output | 3 | Selected input channel |
| adc_pwr | output | 1 | Analog core power enable |
| irq | output | 1 | Interrupt request |

## Verification
Control fields, power and channel update on the write edge and are visible in the cycle after it. Read data is due one cycle after the strobe. The first trial code is due D cycles after the start edge, and the result, status and busy drop are due RES_BITS cycles after that. The bench keeps a behavioural model that counts elapsed cycles from the start edge and derives each expected trial code from the input level the comparator is modelling. It updates that model on the same rising edge as the design and compares all outputs at the following falling edge. Settling counts of 0, 3 and 8 place the first trial at different offsets, and an abort and a repeated power write land in the middle of a sequence.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int IDX_RESULT = 0;
  localparam int IDX_STATUS = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_SETTLE = 3;

  localparam int CTL_CHAN_LSB = 0;
  localparam int CTL_PWR      = 3;
  localparam int CTL_IEN      = 5;
  localparam int CTL_ISTS     = 6;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_CONV   = 2'd2
  } sq_state_t;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int RES_BITS   = 10,
  parameter int DLY_W      = 6,
  parameter int DLY_RESET  = 8,
  parameter int CHAN_W     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  input  logic                seq_busy,
  input  logic                seq_done,
  input  logic [RES_BITS-1:0] seq_result,
  output logic                seq_start,
  output logic                seq_kill,
  output logic [DLY_W-1:0]    settle_cnt,
  output logic [CHAN_W-1:0]   chan_q,
  output logic                pwr_q,
  output logic                ien_q,
  output logic                ists_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             ctl_wr;
  logic             dly_wr;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign ctl_wr = bus_wr && (idx == IDX_W'(IDX_CTRL));
  assign dly_wr = bus_wr && (idx == IDX_W'(IDX_SETTLE));

  assign seq_start = ctl_wr && bus_wdata[CTL_PWR] && !pwr_q;
  assign seq_kill  = ctl_wr && !bus_wdata[CTL_PWR];
  assign unused_bits = ^{bus_wdata[31:7], bus_wdata[4], bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q     <= '0;
      pwr_q      <= 1'b0;
      ien_q      <= 1'b0;
      ists_q     <= 1'b0;
      settle_cnt <= DLY_W'(DLY_RESET);
    end else begin
      if (ctl_wr) begin
        chan_q <= bus_wdata[CTL_CHAN_LSB +: CHAN_W];
        pwr_q  <= bus_wdata[CTL_PWR];
        ien_q  <= bus_wdata[CTL_IEN];
      end
      if (seq_done)
        ists_q <= 1'b1;
      else if (ctl_wr)
        ists_q <= ists_q & bus_wdata[CTL_ISTS];
      if (dly_wr)
        settle_cnt <= bus_wdata[DLY_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(IDX_RESULT): rd_mux = 32'(seq_result);
      IDX_W'(IDX_STATUS): rd_mux = {31'd0, seq_busy};
      IDX_W'(IDX_CTRL): begin
        rd_mux[CTL_CHAN_LSB +: CHAN_W] = chan_q;
        rd_mux[CTL_PWR]                = pwr_q;
        rd_mux[CTL_IEN]                = ien_q;
        rd_mux[CTL_ISTS]               = ists_q;
      end
      IDX_W'(IDX_SETTLE): rd_mux = 32'(settle_cnt);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  p_done_sets_ists_r6: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> ists_q);
  p_clear_on_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && bus_wdata == 32'd0 && !seq_done) |=> (!ists_q && !pwr_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int DLY_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                kill,
  input  logic [DLY_W-1:0]    settle_cnt,
  input  logic                cmp_in,
  output logic                busy,
  output logic                done,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result
);
  localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  sq_state_t            state_q;
  logic [DLY_W-1:0]     cnt_q;
  logic [RES_BITS-1:0]  mask_q;
  logic [RES_BITS-1:0]  acc_q;
  logic [RES_BITS-1:0]  acc_next;

  assign busy     = (state_q != SQ_IDLE);
  assign done     = (state_q == SQ_CONV) && mask_q[0] && !kill;
  assign acc_next = cmp_in ? (acc_q | mask_q) : acc_q;
  assign dac_code = (state_q == SQ_CONV) ? (acc_q | mask_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      mask_q  <= '0;
      acc_q   <= '0;
      result  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            acc_q <= '0;
            if (settle_cnt == '0) begin
              state_q <= SQ_CONV;
              mask_q  <= MSB_MASK;
            end else begin
              state_q <= SQ_SETTLE;
              cnt_q   <= settle_cnt;
            end
          end
        end
        SQ_SETTLE: begin
          if (kill) begin
            state_q <= SQ_IDLE;
          end else if (cnt_q == DLY_W'(1)) begin
            state_q <= SQ_CONV;
            mask_q  <= MSB_MASK;
          end else begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        SQ_CONV: begin
          if (kill) begin
            state_q <= SQ_IDLE;
            mask_q  <= '0;
            acc_q   <= '0;
          end else if (mask_q[0]) begin
            result  <= acc_next;
            state_q <= SQ_IDLE;
            mask_q  <= '0;
            acc_q   <= '0;
          end else begin
            mask_q <= mask_q >> 1;
            acc_q  <= acc_next;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  p_kill_idle_r9: assert property (@(posedge clk) disable iff (rst)
    kill |=> !busy);
  p_mask_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_q));
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result));
endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top
  import sar_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int RES_BITS  = 10,
  parameter int DLY_W     = 6,
  parameter int DLY_RESET = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [2:0]          adc_chan,
  output logic                adc_pwr,
  output logic                irq
);
  localparam int CHAN_W = 3;

  logic                start, kill, busy, done;
  logic                ien, ists;
  logic [DLY_W-1:0]    settle_cnt;
  logic [RES_BITS-1:0] result;

  sar_regs #(
    .ADDR_W(ADDR_W), .RES_BITS(RES_BITS), .DLY_W(DLY_W),
    .DLY_RESET(DLY_RESET), .CHAN_W(CHAN_W)
  ) i_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .seq_busy(busy), .seq_done(done), .seq_result(result),
    .seq_start(start), .seq_kill(kill), .settle_cnt(settle_cnt),
    .chan_q(adc_chan), .pwr_q(adc_pwr), .ien_q(ien), .ists_q(ists)
  );

  sar_seq #(
    .RES_BITS(RES_BITS), .DLY_W(DLY_W)
  ) i_seq (
    .clk(clk), .rst(rst),
    .start(start), .kill(kill), .settle_cnt(settle_cnt), .cmp_in(cmp_in),
    .busy(busy), .done(done), .dac_code(dac_code), .result(result)
  );

  assign irq = ists & ien;

  p_unpowered_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !adc_pwr |-> !busy);
  p_done_when_powered_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> adc_pwr);
endmodule

// File: tb/test_sar_ctrl_top.sv
module test_sar_ctrl_top;
  localparam int RES = 10;
  localparam int AW  = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_rdata;
  logic            cmp_in;
  logic [RES-1:0]  dac_code;
  logic [2:0]      adc_chan;
  logic            adc_pwr;
  logic            irq;

  int vin = 0;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // behavioural model state
  int m_pwr, m_chan, m_ien, m_ists, m_dly, m_busy, m_t, m_run_dly, m_res;
  int exp_rd;
  bit rd_pend = 0;

  always #4 clk = ~clk;

  sar_ctrl_top #(.ADDR_W(AW), .RES_BITS(RES)) i_sar_ctrl_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cmp_in(cmp_in), .dac_code(dac_code), .adc_chan(adc_chan),
    .adc_pwr(adc_pwr), .irq(irq)
  );

  // comparator model: trial code at or below the input level keeps the bit
  assign cmp_in = (int'(dac_code) <= vin);

  function automatic int model_read(int a);
    case (a >> 2)
      0: return m_res;
      1: return m_busy;
      2: return m_chan | (m_pwr << 3) | (m_ien << 5) | (m_ists << 6);
      3: return m_dly;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_dac();
    int k;
    if (m_busy == 0 || m_t < m_run_dly) return 0;
    k = RES - 1 - (m_t - m_run_dly);
    return ((vin >> (k + 1)) << (k + 1)) | (1 << k);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pwr = 0; m_chan = 0; m_ien = 0; m_ists = 0; m_dly = 8;
      m_busy = 0; m_t = 0; m_run_dly = 0; m_res = 0; rd_pend = 0;
    end else begin
      bit ctl, done_now, kill, start;
      rd_pend = bus_rd;
      if (bus_rd) exp_rd = model_read(int'(bus_addr));
      ctl   = bus_wr && (bus_addr >> 2) == 2;
      kill  = ctl && !bus_wdata[3];
      start = ctl && bus_wdata[3] && m_pwr == 0;
      done_now = m_busy != 0 && !kill && m_t == m_run_dly + RES - 1;
      if (m_busy != 0) begin
        if (kill || done_now) m_busy = 0;
        else m_t++;
      end
      if (done_now) m_res = vin;
      if (ctl) begin
        m_chan = int'(bus_wdata[2:0]);
        m_pwr  = int'(bus_wdata[3]);
        m_ien  = int'(bus_wdata[5]);
        m_ists = m_ists & int'(bus_wdata[6]);
      end
      if (done_now) m_ists = 1;
      if (start) begin m_busy = 1; m_t = 0; m_run_dly = m_dly; end
      if (bus_wr && (bus_addr >> 2) == 3) m_dly = int'(bus_wdata[5:0]);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R10 adc_pwr", int'(adc_pwr), m_pwr);
      check("R10 adc_chan", int'(adc_chan), m_chan);
      check("R7 irq", int'(irq), m_ists & m_ien);
      check("R4 R5 dac_code", int'(dac_code), exp_dac());
      if (rd_pend) check("R2 bus_rdata", int'(bus_rdata), exp_rd);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(int a, int exp, string tag);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, int'(bus_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", int'(irq), 0);
    check("R1 dac_code", int'(dac_code), 0);
    check("R1 adc_pwr", int'(adc_pwr), 0);
    rd_expect(0, 0, "R1 result");
    rd_expect(4, 0, "R1 status");
    rd_expect(8, 0, "R1 control");
    rd_expect(12, 8, "R1 settle");

    // default settling 8, channel 5, interrupt enabled
    vin = 'h2A5;
    wr(8, 'h2D);
    rd_expect(4, 1, "R3 busy during settle");
    idle(20);
    rd_expect(0, 'h2A5, "R6 result");
    rd_expect(8, 'h6D, "R6 status bit");
    rd_expect(4, 0, "R6 busy cleared");
    check("R7 irq asserted", int'(irq), 1);
    wr(8, 0);
    rd_expect(8, 0, "R8 cleared by zero write");
    check("R8 irq low", int'(irq), 0);

    // zero settling, full-scale input, interrupt disabled
    wr(12, 0);
    vin = 'h3FF;
    wr(8, 'h08);
    idle(14);
    rd_expect(0, 'h3FF, "R4 R6 zero settle result");
    rd_expect(8, 'h48, "R7 status with enable off");
    check("R7 irq gated", int'(irq), 0);
    wr(8, 0);
    wr(8, 'h60);
    rd_expect(8, 'h20, "R8 status not settable");

    // abort in mid conversion
    wr(12, 3);
    vin = 'h155;
    wr(8, 'h2A);
    idle(6);
    wr(8, 'h20);
    rd_expect(4, 0, "R9 idle after abort");
    rd_expect(0, 'h3FF, "R9 result kept");
    rd_expect(8, 'h20, "R9 status not set");

    // abort during settling
    wr(12, 40);
    wr(8, 'h29);
    idle(5);
    wr(8, 0);
    rd_expect(4, 0, "R9 settle abort idle");

    // repeated power write does not restart
    wr(12, 3);
    vin = 0;
    wr(8, 'h2B);
    idle(2);
    wr(8, 'h2B);
    idle(12);
    rd_expect(0, 0, "R3 single conversion result");
    rd_expect(4, 0, "R3 no restart");
    check("R7 irq after zero code", int'(irq), 1);
    wr(8, 0);

    // register decode edges
    wr(12, 'hFF);
    rd_expect(12, 'h3F, "R2 settle field width");
    rd_expect(16, 0, "R2 unmapped index");
    rd_expect(28, 0, "R2 unmapped top index");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule